// File: doc/BRIEF.md
# LIN Header Receive Gating Controller

This block holds the control settings for the receive front end of a LIN node and decides where the serial receive line goes at each point of a frame header. When the node is idle, the receive line passes straight through to the UART. When software arms header capture, the line is cut off from the UART (held at the idle-high level) and sent to a break/sync timer instead. The UART sees the bus again once the header reaches a chosen milestone. In master mode, the timer output is also ORed onto the transmit pin so the timer can drive the break.

Break-length timing and baud measurement happen outside this block. Their results arrive as single-cycle event pulses: break detected, sync field measured, and bus collision. Each event sets a sticky flag that software clears by writing ones to it. Each event also raises the interrupt request in the same cycle when its enable bit is set.

Register map: address 0 is the control register, address 1 is the auxiliary register, and address 2 holds the event flags.

Top module: `lin_rx_gate`

## Requirements
- R1: After reset, every readable register reads 0, `uart_rxd` follows `rxd_in`, `tmr_in` is 1, and `txd_pin` equals `uart_txd`.
- R2: Control bit 7 enables LIN operation. A control write with bit 7 and bit 4 (arm) both set has two effects from the next cycle: `uart_rxd` is held at 1, and `tmr_in` follows `rxd_in`. Bit 4 always reads back 0.
- R3: Control bit 3 is read-only. It reads 1 while the UART input is masked and 0 otherwise.
- R4: In slave mode (bit 6 = 0) with select bit 5 = 0, a break event releases the mask, and the line returns to the UART from the next cycle. A sync event has no effect on the mask.
- R5: In slave mode with bit 5 = 1, a sync event releases the mask. A break event has no effect on the mask.
- R6: In master mode, a break event releases the mask whatever the value of bit 5. A sync event does not release it.
- R7: While LIN is enabled in master mode, `txd_pin` = `tmr_out` OR `uart_txd`. Otherwise `txd_pin` = `uart_txd`.
- R8: A control write that sets bit 7 while it was 0 masks the UART input from the next cycle, even without arm. The timer input stays at 1.
- R9: A write to control bit 6 is ignored while bit 7 currently reads 1.
- R10: A control write that clears bit 7 restores all routing to the R1 defaults and clears the mask.
- R11: Auxiliary bit 0 is read/write, and its other bits read 0. The collision event counts only while auxiliary bit 0 is 1.
- R12: The event flags are bit 0 sync, bit 1 break and bit 2 collision, at address 2. They are set only while LIN is enabled. Writing 1 to a flag bit clears that flag. `irq` is the same-cycle OR of each counted event ANDed with its enable: control bit 0 for sync, bit 1 for break, bit 2 for collision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both read and write |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `reg_addr` |
| rxd_in | input | 1 | Raw serial receive line |
| tmr_out | input | 1 | Timer output (master break drive) |
| uart_txd | input | 1 | UART transmit data |
| ev_sync | input | 1 | Sync field measured pulse |
| ev_break | input | 1 | Break detected pulse |
| ev_coll | input | 1 | Bus collision pulse |
| uart_rxd | output | 1 | Gated receive line to the UART |
| tmr_in | output | 1 | Timer capture input |
| txd_pin | output | 1 | Transmit pin drive |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and three event sources. This is the full event set, so all three flag bits, all three enables and the collision gate can be reached. The directed tasks walk the mask through each release path (slave on break, slave on sync, master on break). They then try the mismatched event on each path, lock-write the mode bit while running, and check that clearing the enable bit restores the default routing.

// File: rtl/lin_gate_pkg.sv
package lin_gate_pkg;
  // control register bit positions (software decodes these)
  localparam int unsigned CB_SFIE  = 0;
  localparam int unsigned CB_BKIE  = 1;
  localparam int unsigned CB_BCIE  = 2;
  localparam int unsigned CB_MSKST = 3;
  localparam int unsigned CB_ARM   = 4;
  localparam int unsigned CB_RLSEL = 5;
  localparam int unsigned CB_MSTR  = 6;
  localparam int unsigned CB_RUN   = 7;
  // register addresses
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_AUX   = 2'd1;
  localparam logic [1:0] A_FLAGS = 2'd2;
  // event indices, same order as the enable bits
  localparam int unsigned EV_SYNC = 0;
  localparam int unsigned EV_BRK  = 1;
  localparam int unsigned EV_COLL = 2;
endpackage

// File: rtl/lin_gate_regs.sv
module lin_gate_regs
  import lin_gate_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     reg_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NEV-1:0] ie_q,
  output logic           rel_q,
  output logic           mst_q,
  output logic           run_q,
  output logic           coll_en_q,
  output logic           run_set,
  output logic           run_clr,
  output logic           arm_pulse
);
  logic           wr_ctrl, wr_aux;
  logic [NEV-1:0] ie_d;
  logic           rel_d, mst_d, run_d, coll_en_d;

  assign wr_ctrl   = wr_en && (reg_addr == A_CTRL);
  assign wr_aux    = wr_en && (reg_addr == A_AUX);
  assign run_set   = wr_ctrl && wr_data[CB_RUN] && !run_q;
  assign run_clr   = wr_ctrl && !wr_data[CB_RUN] && run_q;
  assign arm_pulse = wr_ctrl && wr_data[CB_RUN] && wr_data[CB_ARM];

  always_comb begin
    ie_d      = ie_q;
    rel_d     = rel_q;
    mst_d     = mst_q;
    run_d     = run_q;
    coll_en_d = coll_en_q;
    if (wr_ctrl) begin
      ie_d  = wr_data[NEV-1:0];
      rel_d = wr_data[CB_RLSEL];
      run_d = wr_data[CB_RUN];
      if (!run_q) mst_d = wr_data[CB_MSTR];
    end
    if (wr_aux) coll_en_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= '0;
      rel_q     <= 1'b0;
      mst_q     <= 1'b0;
      run_q     <= 1'b0;
      coll_en_q <= 1'b0;
    end else if (wr_en) begin
      ie_q      <= ie_d;
      rel_q     <= rel_d;
      mst_q     <= mst_d;
      run_q     <= run_d;
      coll_en_q <= coll_en_d;
    end
  end
endmodule

// File: rtl/lin_gate_seq.sv
module lin_gate_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic run_q,
  input  logic mst_q,
  input  logic rel_q,
  input  logic run_set,
  input  logic run_clr,
  input  logic arm_pulse,
  input  logic ev_sync,
  input  logic ev_break,
  output logic masked_q,
  output logic armed_q
);
  logic release_ev, masked_d, armed_d;

  // master ignores the select bit and releases at the end of break
  assign release_ev = mst_q ? ev_break : (rel_q ? ev_sync : ev_break);

  always_comb begin
    masked_d = masked_q;
    armed_d  = armed_q;
    if (run_clr) begin
      masked_d = 1'b0;
      armed_d  = 1'b0;
    end else if (arm_pulse) begin
      masked_d = 1'b1;
      armed_d  = 1'b1;
    end else if (run_set) begin
      masked_d = 1'b1;
    end else if (run_q && armed_q && release_ev) begin
      masked_d = 1'b0;
      armed_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      masked_q <= masked_d;
      armed_q  <= armed_d;
    end
  end
endmodule

// File: rtl/lin_gate_evt.sv
module lin_gate_evt #(
  parameter int unsigned NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_q,
  input  logic [NEV-1:0] ev_in,
  input  logic [NEV-1:0] ev_gate,
  input  logic [NEV-1:0] ie_q,
  input  logic           clr_wr,
  input  logic [NEV-1:0] clr_mask,
  output logic [NEV-1:0] flag_q,
  output logic           irq
);
  logic [NEV-1:0] hit, flag_d;

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    assign hit[i] = ev_in[i] && ev_gate[i] && run_q;
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr_wr && clr_mask[i]) flag_d[i] = 1'b0;
      if (hit[i]) flag_d[i] = 1'b1;
    end
  end

  assign irq = |(hit & ie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/lin_rx_gate.sv
module lin_rx_gate
  import lin_gate_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rxd_in,
  input  logic          tmr_out,
  input  logic          uart_txd,
  input  logic          ev_sync,
  input  logic          ev_break,
  input  logic          ev_coll,
  output logic          uart_rxd,
  output logic          tmr_in,
  output logic          txd_pin,
  output logic          irq
);
  localparam int unsigned NEV = 3;

  logic [NEV-1:0] ie_q, flag_q, ev_vec, ev_gate;
  logic rel_q, mst_q, run_q, coll_en_q, run_set, run_clr, arm_pulse;
  logic masked_q, armed_q;

  lin_gate_regs #(.DW(DW), .NEV(NEV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .ie_q(ie_q), .rel_q(rel_q), .mst_q(mst_q),
    .run_q(run_q), .coll_en_q(coll_en_q), .run_set(run_set),
    .run_clr(run_clr), .arm_pulse(arm_pulse)
  );

  lin_gate_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .mst_q(mst_q), .rel_q(rel_q),
    .run_set(run_set), .run_clr(run_clr), .arm_pulse(arm_pulse),
    .ev_sync(ev_sync), .ev_break(ev_break),
    .masked_q(masked_q), .armed_q(armed_q)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_SYNC]  = ev_sync;
    ev_vec[EV_BRK]   = ev_break;
    ev_vec[EV_COLL]  = ev_coll;
    ev_gate          = '1;
    ev_gate[EV_COLL] = coll_en_q;
  end

  lin_gate_evt #(.NEV(NEV)) u_evt (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .ev_in(ev_vec),
    .ev_gate(ev_gate), .ie_q(ie_q),
    .clr_wr(wr_en && (reg_addr == A_FLAGS)), .clr_mask(wr_data[NEV-1:0]),
    .flag_q(flag_q), .irq(irq)
  );

  // pin routing
  assign uart_rxd = (run_q && masked_q) ? 1'b1 : rxd_in;
  assign tmr_in   = (run_q && armed_q) ? rxd_in : 1'b1;
  assign txd_pin  = (run_q && mst_q) ? (tmr_out | uart_txd) : uart_txd;

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_data[NEV-1:0] = ie_q;
        rd_data[CB_MSKST] = run_q && masked_q;
        rd_data[CB_RLSEL] = rel_q;
        rd_data[CB_MSTR]  = mst_q;
        rd_data[CB_RUN]   = run_q;
      end
      A_AUX:   rd_data[0] = coll_en_q;
      A_FLAGS: rd_data[NEV-1:0] = flag_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lin_rx_gate_chk.sv
module lin_rx_gate_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          rxd_in,
  input logic          tmr_out,
  input logic          uart_txd,
  input logic          ev_sync,
  input logic          ev_break,
  input logic          uart_rxd,
  input logic          tmr_in,
  input logic          txd_pin,
  input logic          run_q,
  input logic          mst_q,
  input logic          rel_q,
  input logic          masked_q,
  input logic          armed_q
);
  a_r2_arm_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 2'd0 && wr_data[7] && wr_data[4]) |=> (uart_rxd == 1'b1 && tmr_in == rxd_in));

  a_r3_status_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0 && rd_data[3]) |-> uart_rxd);

  a_r4_break_release: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !mst_q && !rel_q && armed_q && ev_break && !wr_en) |=> !masked_q);

  a_r5_sync_release: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !mst_q && rel_q && armed_q && ev_sync && !wr_en) |=> !masked_q);

  a_r7_tx_or: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mst_q) |-> (txd_pin == (tmr_out | uart_txd)));

  a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && reg_addr == 2'd0) |=> $stable(mst_q));

  a_r10_idle_route: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (uart_rxd == rxd_in && tmr_in && txd_pin == uart_txd));
endmodule

bind lin_rx_gate lin_rx_gate_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .rd_data(rd_data), .rxd_in(rxd_in), .tmr_out(tmr_out),
  .uart_txd(uart_txd), .ev_sync(ev_sync), .ev_break(ev_break),
  .uart_rxd(uart_rxd), .tmr_in(tmr_in), .txd_pin(txd_pin),
  .run_q(run_q), .mst_q(mst_q), .rel_q(rel_q),
  .masked_q(masked_q), .armed_q(armed_q)
);

// File: tb/test_lin_rx_gate.sv
module test_lin_rx_gate;
  localparam int unsigned DW = 8;

  logic clk, rst_n, wr_en, rxd_in, tmr_out, uart_txd;
  logic ev_sync, ev_break, ev_coll;
  logic [1:0] reg_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic uart_rxd, tmr_in, txd_pin, irq;
  int n_chk, n_bad;

  lin_rx_gate #(.DW(DW)) i_lin_rx_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .rxd_in(rxd_in), .tmr_out(tmr_out),
    .uart_txd(uart_txd), .ev_sync(ev_sync), .ev_break(ev_break),
    .ev_coll(ev_coll), .uart_rxd(uart_rxd), .tmr_in(tmr_in),
    .txd_pin(txd_pin), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; reg_addr = 2'd0; wr_data = '0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, rd_data, exp);
    reg_addr = 2'd0;
  endtask

  // which: 0 sync, 1 break, 2 coll; checks irq during the pulse
  task automatic pulse(input int which, input logic exp_irq, input string req);
    @(negedge clk);
    ev_sync = (which == 0); ev_break = (which == 1); ev_coll = (which == 2);
    #1;
    chk(req, {7'd0, irq}, {7'd0, exp_irq});
    @(negedge clk);
    ev_sync = 1'b0; ev_break = 1'b0; ev_coll = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 2'd0, 8'h00);
    rd_chk("R1 aux", 2'd1, 8'h00);
    rd_chk("R1 flags", 2'd2, 8'h00);
    rxd_in = 1'b0; uart_txd = 1'b0; tmr_out = 1'b1; #1;
    chk("R1 uart_rxd", {7'd0, uart_rxd}, 8'h00);
    chk("R1 tmr_in", {7'd0, tmr_in}, 8'h01);
    chk("R1 txd_pin", {7'd0, txd_pin}, 8'h00);
  endtask

  task automatic t_slave_break;
    rxd_in = 1'b0;
    wr(2'd0, 8'h92);
    chk("R2 uart masked", {7'd0, uart_rxd}, 8'h01);
    chk("R2 timer routed", {7'd0, tmr_in}, 8'h00);
    rd_chk("R3 status set, R2 arm reads 0", 2'd0, 8'h8A);
    pulse(0, 1'b0, "R12 sync irq disabled");
    chk("R4 sync ignored", {7'd0, uart_rxd}, 8'h01);
    pulse(1, 1'b1, "R12 break irq");
    chk("R4 break releases", {7'd0, uart_rxd}, 8'h00);
    chk("R4 timer idle", {7'd0, tmr_in}, 8'h01);
    rd_chk("R3 status clear", 2'd0, 8'h82);
    rd_chk("R12 flags sticky", 2'd2, 8'h03);
    wr(2'd2, 8'h02);
    rd_chk("R12 w1c one bit", 2'd2, 8'h01);
    wr(2'd2, 8'h01);
    rd_chk("R12 w1c all", 2'd2, 8'h00);
  endtask

  task automatic t_slave_sync;
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hB1);
    pulse(1, 1'b0, "R12 break irq disabled");
    chk("R5 break ignored", {7'd0, uart_rxd}, 8'h01);
    pulse(0, 1'b1, "R12 sync irq");
    chk("R5 sync releases", {7'd0, uart_rxd}, 8'h00);
    wr(2'd2, 8'h07);
  endtask

  task automatic t_run_rise_lock;
    wr(2'd0, 8'h00);
    chk("R10 cleared route", {7'd0, uart_rxd}, 8'h00);
    wr(2'd0, 8'h80);
    chk("R8 masked on enable", {7'd0, uart_rxd}, 8'h01);
    chk("R8 timer idle", {7'd0, tmr_in}, 8'h01);
    wr(2'd0, 8'hC0);
    rd_chk("R9 mode write ignored", 2'd0, 8'h88);
    wr(2'd0, 8'h00);
    rd_chk("R10 ctrl cleared", 2'd0, 8'h00);
    chk("R10 uart follows", {7'd0, uart_rxd}, 8'h00);
    chk("R10 timer idle", {7'd0, tmr_in}, 8'h01);
  endtask

  task automatic t_master;
    wr(2'd0, 8'h40);
    rd_chk("R9 mode write when stopped", 2'd0, 8'h40);
    tmr_out = 1'b1; uart_txd = 1'b0; #1;
    chk("R7 no OR while stopped", {7'd0, txd_pin}, 8'h00);
    wr(2'd0, 8'hF0);
    chk("R7 OR in master", {7'd0, txd_pin}, 8'h01);
    tmr_out = 1'b0; uart_txd = 1'b1; #1;
    chk("R7 OR uart side", {7'd0, txd_pin}, 8'h01);
    tmr_out = 1'b0; uart_txd = 1'b0; #1;
    chk("R7 OR low", {7'd0, txd_pin}, 8'h00);
    pulse(0, 1'b0, "R12 no enable");
    chk("R6 sync ignored", {7'd0, uart_rxd}, 8'h01);
    pulse(1, 1'b0, "R12 no enable");
    chk("R6 break releases", {7'd0, uart_rxd}, 8'h00);
    wr(2'd0, 8'h00);
    rd_chk("R9 mode kept on stop", 2'd0, 8'h40);
    tmr_out = 1'b1; #1;
    chk("R10 tx default", {7'd0, txd_pin}, 8'h00);
    wr(2'd2, 8'h07);
  endtask

  task automatic t_aux;
    wr(2'd1, 8'hFF);
    rd_chk("R11 aux bit0 only", 2'd1, 8'h01);
    wr(2'd0, 8'h84);
    pulse(2, 1'b1, "R11 coll irq when enabled");
    rd_chk("R12 coll flag", 2'd2, 8'h04);
    wr(2'd2, 8'h04);
    wr(2'd1, 8'h00);
    pulse(2, 1'b0, "R11 coll irq gated");
    rd_chk("R11 coll flag gated", 2'd2, 8'h00);
    wr(2'd0, 8'h00);
    pulse(1, 1'b0, "R12 stopped irq");
    rd_chk("R12 no flag while stopped", 2'd2, 8'h00);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; reg_addr = 2'd0; wr_data = '0;
    rxd_in = 1'b1; tmr_out = 1'b0; uart_txd = 1'b1;
    ev_sync = 1'b0; ev_break = 1'b0; ev_coll = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset;
    t_slave_break;
    t_slave_sync;
    t_run_rise_lock;
    t_master;
    t_aux;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule